// File: doc/BRIEF.md
# CSR Read-Modify-Write Unit

This block carries out the six control-register access operations of a 32-bit processor: an atomic swap, an atomic bit-set and an atomic bit-clear, each available with a register source or with a 5-bit immediate source. It works on a small bank of 32-bit control registers. Each accepted request reads the selected register and updates it at the same clock edge, so the value handed back for writeback to the destination register is always the contents from before that request. Requests may arrive every cycle. Each result appears exactly one cycle after its request.

The unit also applies the rules that suppress side effects. A swap whose destination is x0 returns no data. A set or clear whose mask source field is zero leaves the register untouched. An unmapped address or a reserved operation code raises an illegal flag and has no effect at all. A separate read-only output shows the saved exception-PC register at all times, so a return-from-trap path can load its program counter from it.

A three-state response machine sequences the results. ST_IDLE means no response is pending. ST_ACK means a legal response is on the outputs. ST_FAULT means an illegal response is on the outputs. From any of these states, a cycle with `req_valid` high moves the machine to ST_ACK if the access is legal and to ST_FAULT if it is not. A cycle with `req_valid` low returns it to ST_IDLE.

Top module: `csr_rmw_unit`

## Requirements
- R1: After reset every implemented register reads zero, `rsp_valid` and `rsp_illegal` are low, and `epc_pc` is zero.
- R2: For every cycle with `req_valid` high, `rsp_valid` is high in the following cycle and low otherwise. `rsp_rd` echoes the request's destination index. When `rsp_wb` is high, `rsp_data` is the register value from before this request's update, and requests may be issued back to back.
- R3: Swap operations write their source into the register. Operation code 3'b001 takes the source from `req_src_val`. Operation code 3'b101 takes the 5-bit `req_src_idx` field zero-extended to 32 bits.
- R4: Set operations write the old value ORed with the mask. Their codes are 3'b010 (register mask) and 3'b110 (immediate mask). Clear operations write the old value ANDed with the inverted mask. Their codes are 3'b011 (register mask) and 3'b111 (immediate mask). The mask sources follow the same rule as in R3.
- R5: A set or clear whose `req_src_idx` field is zero, whether that field names register x0 or is an immediate of zero, leaves the register unchanged. It still returns the old value when the destination is not x0.
- R6: `rsp_wb` is high only for a legal access whose `req_rd` is nonzero. Whenever `rsp_wb` is low, `rsp_data` is zero. In particular, a swap to x0 returns no data but still writes the register.
- R7: The implemented addresses are 12'h300, 12'h305, 12'h340 and 12'h341. Any other address gives `rsp_illegal` high with `rsp_wb` low, and no register changes.
- R8: Operation codes 3'b000 and 3'b100 are reserved. They give `rsp_illegal` high with `rsp_wb` low, and no register changes.
- R9: `epc_pc` always equals the register at address 12'h341. A write to that register is visible on `epc_pc` one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one operation per cycle |
| req_op | input | 3 | Operation code (see R3, R4, R8) |
| req_addr | input | 12 | Control register address |
| req_rd | input | 5 | Destination register index |
| req_src_idx | input | 5 | Source register index or 5-bit immediate |
| req_src_val | input | 32 | Value of the source register |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Pre-update register value for writeback |
| rsp_wb | output | 1 | Writeback enable |
| rsp_rd | output | 5 | Destination index of the response |
| rsp_illegal | output | 1 | Unmapped address or reserved operation |
| epc_pc | output | 32 | Current exception-PC register contents |

## Verification
The assertions assume that every request field is driven to a known value whenever `req_valid` is high. They place no constraint on the operation code or the address, because reserved codes and unmapped addresses are part of the defined behaviour. The stimulus changes all inputs only on the falling clock edge and holds them steady across the rising edge. It walks every legal operation against every implemented register with zero, small and all-ones source fields and with zero and nonzero destinations. It then sweeps all 4096 addresses and both reserved codes, so every input combination the checks depend on is reached with defined values.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

    localparam int CSR_XLEN   = 32;
    localparam int CSR_ADDR_W = 12;
    localparam int CSR_IDX_W  = 5;
    localparam int CSR_COUNT  = 4;
    localparam int CSR_EPC_SLOT = 3;

    // Operation code; bit 2 selects the immediate source, bits 1:0 the kind.
    typedef enum logic [2:0] {
        OP_RSV0 = 3'b000,
        OP_SWAP = 3'b001,
        OP_SETB = 3'b010,
        OP_CLRB = 3'b011,
        OP_RSV4 = 3'b100,
        OP_SWPI = 3'b101,
        OP_SETI = 3'b110,
        OP_CLRI = 3'b111
    } csr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ACK   = 2'b01,
        ST_FAULT = 2'b10
    } rsp_state_e;

    // Address of each implemented slot; the last slot holds the exception PC.
    function automatic logic [CSR_ADDR_W-1:0] csr_addr_of(input int slot);
        logic [CSR_ADDR_W-1:0] a;
        case (slot)
            0:       a = 12'h300;
            1:       a = 12'h305;
            2:       a = 12'h340;
            default: a = 12'h341;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_rmw_pkg::*;
#(
    parameter int ADDR_W  = CSR_ADDR_W,
    parameter int NUM_CSR = CSR_COUNT
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic [NUM_CSR-1:0] sel
);

    // One comparator per implemented slot.
    for (genvar g = 0; g < NUM_CSR; g++) begin : g_match
        assign sel[g] = (addr == ADDR_W'(csr_addr_of(g)));
    end

    assign hit = |sel;

endmodule

// File: rtl/csr_op_alu.sv
module csr_op_alu
    import csr_rmw_pkg::*;
#(
    parameter int XLEN  = CSR_XLEN,
    parameter int IDX_W = CSR_IDX_W
) (
    input  logic [2:0]      op,
    input  logic [IDX_W-1:0] src_idx,
    input  logic [XLEN-1:0] src_val,
    input  logic [XLEN-1:0] old_val,
    input  logic [IDX_W-1:0] rd,
    output logic            op_ok,
    output logic            wr_req,
    output logic            rd_req,
    output logic [XLEN-1:0] new_val
);

    csr_op_e         op_e;
    logic [XLEN-1:0] operand;
    logic            mask_zero;
    logic            rd_live;

    assign op_e      = csr_op_e'(op);
    assign operand   = op[2] ? XLEN'(src_idx) : src_val;
    assign mask_zero = (src_idx == '0);
    assign rd_live   = (rd != '0);

    always_comb begin
        op_ok   = 1'b0;
        wr_req  = 1'b0;
        rd_req  = 1'b0;
        new_val = old_val;
        case (op_e)
            OP_SWAP, OP_SWPI: begin
                op_ok   = 1'b1;
                wr_req  = 1'b1;
                rd_req  = rd_live;   // no read at all when the target is x0
                new_val = operand;
            end
            OP_SETB, OP_SETI: begin
                op_ok   = 1'b1;
                wr_req  = !mask_zero;
                rd_req  = rd_live;
                new_val = old_val | operand;
            end
            OP_CLRB, OP_CLRI: begin
                op_ok   = 1'b1;
                wr_req  = !mask_zero;
                rd_req  = rd_live;
                new_val = old_val & ~operand;
            end
            default: begin
                op_ok   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_rmw_pkg::*;
#(
    parameter int XLEN     = CSR_XLEN,
    parameter int NUM_CSR  = CSR_COUNT,
    parameter int EPC_SLOT = CSR_EPC_SLOT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_CSR-1:0] wr_sel,
    input  logic [XLEN-1:0]    wr_data,
    input  logic [NUM_CSR-1:0] rd_sel,
    output logic [XLEN-1:0]    rd_data,
    output logic [XLEN-1:0]    epc_q
);

    logic [NUM_CSR-1:0][XLEN-1:0] regs_q;
    logic [NUM_CSR-1:0][XLEN-1:0] gated;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_CSR; i++) begin
                if (wr_sel[i]) begin
                    regs_q[i] <= wr_data;
                end
            end
        end
    end

    // AND-OR read mux, one term per slot.
    for (genvar g = 0; g < NUM_CSR; g++) begin : g_rd
        assign gated[g] = rd_sel[g] ? regs_q[g] : '0;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CSR; i++) begin
            rd_data = rd_data | gated[i];
        end
    end

    assign epc_q = regs_q[EPC_SLOT];

    p_epc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel[EPC_SLOT]) |=> $stable(epc_q));

    p_epc_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel[EPC_SLOT]) |=> (epc_q == $past(wr_data)));

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int XLEN     = CSR_XLEN,
    parameter int ADDR_W   = CSR_ADDR_W,
    parameter int IDX_W    = CSR_IDX_W,
    parameter int NUM_CSR  = CSR_COUNT,
    parameter int EPC_SLOT = CSR_EPC_SLOT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [IDX_W-1:0]  req_rd,
    input  logic [IDX_W-1:0]  req_src_idx,
    input  logic [XLEN-1:0]   req_src_val,
    output logic              rsp_valid,
    output logic [XLEN-1:0]   rsp_data,
    output logic              rsp_wb,
    output logic [IDX_W-1:0]  rsp_rd,
    output logic              rsp_illegal,
    output logic [XLEN-1:0]   epc_pc
);

    rsp_state_e         state_q, state_d;
    logic               hit;
    logic [NUM_CSR-1:0] sel;
    logic               op_ok, wr_req, rd_req;
    logic [XLEN-1:0]    old_val, new_val;
    logic               legal;
    logic               csr_wr_en;
    logic [XLEN-1:0]    data_q;
    logic               wb_q;
    logic [IDX_W-1:0]   rd_q;

    csr_addr_decode #(.ADDR_W(ADDR_W), .NUM_CSR(NUM_CSR)) u_dec (
        .addr (req_addr),
        .hit  (hit),
        .sel  (sel)
    );

    csr_op_alu #(.XLEN(XLEN), .IDX_W(IDX_W)) u_alu (
        .op      (req_op),
        .src_idx (req_src_idx),
        .src_val (req_src_val),
        .old_val (old_val),
        .rd      (req_rd),
        .op_ok   (op_ok),
        .wr_req  (wr_req),
        .rd_req  (rd_req),
        .new_val (new_val)
    );

    assign legal     = hit && op_ok;
    assign csr_wr_en = req_valid && legal && wr_req;

    csr_bank #(.XLEN(XLEN), .NUM_CSR(NUM_CSR), .EPC_SLOT(EPC_SLOT)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (csr_wr_en),
        .wr_sel  (sel),
        .wr_data (new_val),
        .rd_sel  (sel),
        .rd_data (old_val),
        .epc_q   (epc_pc)
    );

    // Next-state logic.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = !req_valid ? ST_IDLE : (legal ? ST_ACK : ST_FAULT);
            ST_ACK:   state_d = !req_valid ? ST_IDLE : (legal ? ST_ACK : ST_FAULT);
            ST_FAULT: state_d = !req_valid ? ST_IDLE : (legal ? ST_ACK : ST_FAULT);
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Response payload, captured together with the register update.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            wb_q   <= 1'b0;
            rd_q   <= '0;
        end else if (req_valid) begin
            data_q <= (legal && rd_req) ? old_val : '0;
            wb_q   <= legal && rd_req;
            rd_q   <= req_rd;
        end
    end

    always_comb begin
        rsp_valid   = 1'b0;
        rsp_illegal = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin rsp_valid = 1'b0; rsp_illegal = 1'b0; end
            ST_ACK:   begin rsp_valid = 1'b1; rsp_illegal = 1'b0; end
            ST_FAULT: begin rsp_valid = 1'b1; rsp_illegal = 1'b1; end
            default:  begin rsp_valid = 1'b0; rsp_illegal = 1'b0; end
        endcase
    end

    assign rsp_data = rsp_valid ? data_q : '0;
    assign rsp_wb   = rsp_valid && wb_q;
    assign rsp_rd   = rd_q;

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_x0_no_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_rd == '0) |=> !rsp_wb);

    p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> (!rsp_wb && rsp_data == '0));

    p_set_keeps_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_en && req_op[1:0] == 2'b10) |-> ((new_val & old_val) == old_val));

    p_clear_adds_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_en && req_op[1:0] == 2'b11) |-> ((new_val & ~old_val) == '0));

    p_zero_mask_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[1] && req_src_idx == '0) |-> !csr_wr_en);

    p_bad_op_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[1:0] == 2'b00) |-> !csr_wr_en);

endmodule

// File: tb/tb_csr_rmw_unit.sv
module tb_csr_rmw_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [11:0] req_addr = '0;
    logic [4:0]  req_rd = '0;
    logic [4:0]  req_src_idx = '0;
    logic [31:0] req_src_val = '0;
    logic        rsp_valid, rsp_wb, rsp_illegal;
    logic [31:0] rsp_data, epc_pc;
    logic [4:0]  rsp_rd;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [4];

    always #5 clk = ~clk;

    csr_rmw_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_rd(req_rd), .req_src_idx(req_src_idx),
        .req_src_val(req_src_val), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_wb(rsp_wb), .rsp_rd(rsp_rd), .rsp_illegal(rsp_illegal), .epc_pc(epc_pc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int slot_of(input logic [11:0] a);
        case (a)
            12'h300: return 0;
            12'h305: return 1;
            12'h340: return 2;
            12'h341: return 3;
            default: return -1;
        endcase
    endfunction

    // Drive one request at a falling edge, check its response one cycle later.
    task automatic issue(input logic [2:0] op, input logic [11:0] addr,
                         input logic [4:0] rd, input logic [4:0] f,
                         input logic [31:0] v, input string tag);
        int          s;
        bit          ok, wr, wb;
        logic [31:0] old, src, nv, ed;
        s   = slot_of(addr);
        ok  = (s >= 0) && (op[1:0] != 2'b00);
        old = (s >= 0) ? mdl[s] : 32'h0;
        src = op[2] ? {27'h0, f} : v;
        wb  = ok && (rd != 5'd0);
        ed  = wb ? old : 32'h0;
        wr  = ok && !(op[1] && f == 5'd0);
        case (op[1:0])
            2'b01:   nv = src;
            2'b10:   nv = old | src;
            default: nv = old & ~src;
        endcase
        req_valid = 1'b1; req_op = op; req_addr = addr; req_rd = rd;
        req_src_idx = f; req_src_val = v;
        @(negedge clk);
        if (wr) mdl[s] = nv;
        chk(rsp_valid == 1'b1, "R2", "rsp_valid", {31'h0, rsp_valid}, 32'h1);
        chk(rsp_rd == rd, "R2", "rsp_rd", {27'h0, rsp_rd}, {27'h0, rd});
        chk(rsp_illegal == !ok, (op[1:0] == 2'b00) ? "R8" : "R7", "rsp_illegal",
            {31'h0, rsp_illegal}, {31'h0, !ok});
        chk(rsp_wb == wb, "R6", "rsp_wb", {31'h0, rsp_wb}, {31'h0, wb});
        chk(rsp_data == ed, tag, "rsp_data", rsp_data, ed);
        chk(epc_pc == mdl[3], "R9", "epc_pc", epc_pc, mdl[3]);
        req_valid = 1'b0;
    endtask

    // Read all four registers back through a zero-mask set with rd=x1.
    task automatic readback(input string tag);
        for (int i = 0; i < 4; i++) begin
            issue(3'b010, slot_of(12'h300) == 0 ? (i == 0 ? 12'h300 : i == 1 ? 12'h305 :
                  i == 2 ? 12'h340 : 12'h341) : 12'h0, 5'd1, 5'd0, 32'hFFFF_FFFF, tag);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) mdl[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
        chk(rsp_illegal == 1'b0, "R1", "rsp_illegal in reset", {31'h0, rsp_illegal}, 32'h0);
        chk(epc_pc == 32'h0, "R1", "epc_pc in reset", epc_pc, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid idle", {31'h0, rsp_valid}, 32'h0);
        readback("R1");
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", "rsp_valid after idle cycle", {31'h0, rsp_valid}, 32'h0);

        // Sweep all legal operations over all slots, fields and destinations.
        for (int a = 0; a < 4; a++) begin
            for (int o = 0; o < 8; o++) begin
                if (o[1:0] == 2'b00) continue;
                for (int k = 0; k < 4; k++) begin
                    for (int r = 0; r < 2; r++) begin
                        logic [4:0]  f;
                        logic [31:0] v;
                        logic [11:0] ad;
                        string       tg;
                        f  = (k == 0) ? 5'd0 : (k == 1) ? 5'd1 : (k == 2) ? 5'd21 : 5'd31;
                        v  = 32'hA5C3_0F96 ^ (32'(a) << 20) ^ (32'(o) * 32'h0101_0101)
                             ^ (32'(k) << 11) ^ 32'(r);
                        ad = (a == 0) ? 12'h300 : (a == 1) ? 12'h305 :
                             (a == 2) ? 12'h340 : 12'h341;
                        if (o[1] && f == 5'd0) tg = "R5";
                        else if (o[1:0] == 2'b01) tg = "R3";
                        else tg = "R4";
                        issue(3'(o), ad, (r == 0) ? 5'd0 : 5'd7, f, v, tg);
                    end
                end
            end
            readback("R4");
        end

        // Back-to-back swaps: each response returns the previous value (R2).
        issue(3'b001, 12'h340, 5'd2, 5'd3, 32'h1234_5678, "R3");
        issue(3'b001, 12'h340, 5'd2, 5'd3, 32'h9ABC_DEF0, "R2");
        issue(3'b101, 12'h340, 5'd2, 5'd17, 32'hFFFF_FFFF, "R2");
        issue(3'b010, 12'h340, 5'd2, 5'd0, 32'h0, "R2");
        // Exception PC loaded, then visible on the side port (R9).
        issue(3'b001, 12'h341, 5'd0, 5'd4, 32'h8000_0104, "R9");
        issue(3'b011, 12'h341, 5'd9, 5'd4, 32'h0000_0004, "R9");

        // Reserved operation codes on every slot (R8).
        for (int a = 0; a < 4; a++) begin
            issue(3'b000, (a == 0) ? 12'h300 : (a == 1) ? 12'h305 :
                  (a == 2) ? 12'h340 : 12'h341, 5'd5, 5'd9, 32'hFFFF_FFFF, "R8");
            issue(3'b100, (a == 0) ? 12'h300 : (a == 1) ? 12'h305 :
                  (a == 2) ? 12'h340 : 12'h341, 5'd5, 5'd9, 32'hFFFF_FFFF, "R8");
        end
        readback("R8");

        // Full address sweep with a non-zero-mask clear (R7): only mapped slots change.
        for (int ad = 0; ad < 4096; ad++) begin
            issue(3'b011, 12'(ad), 5'd1, 5'd1, 32'h0000_0100, "R7");
        end
        readback("R7");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule